// File: doc/BRIEF.md
# Multicycle Datapath Control Sequencer

This block is the hardwired controller of a multicycle processor core. Each instruction runs over several clock cycles. The controller keeps a 4-bit state register that steps through a fixed graph of twelve states. Every instruction first passes through a fetch state and a decode state. The decode state then branches on the 6-bit opcode into a path for that instruction class, and every path ends by returning to fetch.

The outputs are Moore outputs. Each control line depends only on the current state, so every output settles in the same cycle that the state register changes. The opcode is sampled only at the clock edges that leave the decode state and the address-calculation state. Any control line that a state does not use is driven low.

The controller drives the program-counter write enables and the PC source select. It also drives the instruction-register load, the memory read and write strobes and the memory address select. For the register file it drives the write enable, the destination select and the write-data select. For the ALU it drives the operation code and both operand selects. The current state number is brought out as a port so that the rest of the core can observe it.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset forces state 0. While held, the fetch-state outputs of R7 are shown.
- R2: States are plain binary codes 0 to 11 on `state_o`. State 0 (fetch) always goes to state 1 (decode).
- R3: From state 1 the next state is chosen by opcode:
  - 000000 (register-register) goes to 6.
  - 000010 (jump) goes to 9.
  - 000100 (branch-if-equal) goes to 8.
  - 001011 (or-immediate) goes to 10.
  - 100011 (load) and 101011 (store) go to 2.
- R4: From state 2, opcode 101011 goes to 5 and any other opcode goes to 3. State 3 goes to 4, state 6 goes to 7, and state 10 goes to 11.
- R5: States 4, 5, 7, 8, 9 and 11 all go to state 0.
- R6: Any other opcode seen in state 1 sends the machine to state 0. No write enable is asserted on the way.
- R7: Fetch (state 0) asserts `pc_wr`, `ir_wr` and `mem_rd`, with `alu_op`=00 (add), `alu_src_b`=001 and `pc_src`=00. All other outputs are 0.
- R8: `alu_op` is coded 00 add, 01 subtract, 10 function field, 11 OR:
  - States 0 to 5 and 9 use 00.
  - States 6 and 7 use 10.
  - State 8 uses 01.
  - States 10 and 11 use 11.
- R9: `alu_src_b` is coded 000 rt, 001 constant 4, 010 sign-extended immediate, 011 shifted sign-extended immediate, 100 zero-extended immediate:
  - State 0 uses 001 and state 1 uses 011.
  - States 2 to 5 use 010.
  - States 10 and 11 use 100.
  - All other states use 000.
  - `alu_src_a` is 1 in states 2 to 8, 10 and 11, and 0 in states 0, 1 and 9.
- R10: `pc_src` is coded 00 ALU, 01 target register, 10 jump address:
  - State 8 asserts `pc_wr_cond` with `pc_src`=01 and subtract.
  - State 9 asserts `pc_wr` with `pc_src`=10.
  - No other state writes the PC except fetch.
- R11: `reg_wr` is asserted only in states 4, 7 and 11. `mem_to_reg` is asserted only in state 4. `reg_dst` is asserted only in states 6 and 7. `mem_wr` is asserted only in state 5. `iord` is asserted in states 3 and 5. `mem_rd` is asserted in states 0 and 3.
- R12: The opcode has no effect in any state other than 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Instruction opcode field |
| state_o | output | 4 | Current state number |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if ALU result is zero |
| ir_wr | output | 1 | Instruction register load |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| iord | output | 1 | Memory address from ALU (1) or PC (0) |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination is rd (1) or rt (0) |
| mem_to_reg | output | 1 | Write data from memory (1) or ALU (0) |
| alu_op | output | 2 | ALU operation code |
| alu_src_a | output | 1 | First ALU operand is register (1) or PC (0) |
| alu_src_b | output | 3 | Second ALU operand select |
| pc_src | output | 2 | PC source select |

## Verification
An opcode applied while the state register holds 1 or 2 shows its effect one clock edge later. The new state and every control line change together, because the outputs are purely combinational from the state. The bench drives the opcode and samples at falling edges. It compares the state and the full control word exactly one falling edge after each rising edge, so each result is read in the first cycle it is due. Reset is checked the same way, one edge after it is asserted.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int STATE_W = 4;
  localparam int OP_W    = 6;

  localparam logic [STATE_W-1:0] S_FETCH  = 4'd0;
  localparam logic [STATE_W-1:0] S_DECODE = 4'd1;
  localparam logic [STATE_W-1:0] S_ADDR   = 4'd2;
  localparam logic [STATE_W-1:0] S_LDMEM  = 4'd3;
  localparam logic [STATE_W-1:0] S_LDWB   = 4'd4;
  localparam logic [STATE_W-1:0] S_STMEM  = 4'd5;
  localparam logic [STATE_W-1:0] S_REXE   = 4'd6;
  localparam logic [STATE_W-1:0] S_RFIN   = 4'd7;
  localparam logic [STATE_W-1:0] S_BRDONE = 4'd8;
  localparam logic [STATE_W-1:0] S_JMP    = 4'd9;
  localparam logic [STATE_W-1:0] S_ORIEXE = 4'd10;
  localparam logic [STATE_W-1:0] S_ORIFIN = 4'd11;

  localparam logic [OP_W-1:0] OP_RR   = 6'b000000;
  localparam logic [OP_W-1:0] OP_JMP  = 6'b000010;
  localparam logic [OP_W-1:0] OP_BEQ  = 6'b000100;
  localparam logic [OP_W-1:0] OP_ORI  = 6'b001011;
  localparam logic [OP_W-1:0] OP_LD   = 6'b100011;
  localparam logic [OP_W-1:0] OP_ST   = 6'b101011;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_SUB = 2'b01;
  localparam logic [1:0] ALU_FN  = 2'b10;
  localparam logic [1:0] ALU_OR  = 2'b11;

  localparam logic [2:0] SB_RT   = 3'b000;
  localparam logic [2:0] SB_FOUR = 3'b001;
  localparam logic [2:0] SB_SEXT = 3'b010;
  localparam logic [2:0] SB_SHL2 = 3'b011;
  localparam logic [2:0] SB_ZEXT = 3'b100;

  localparam logic [1:0] PCS_ALU = 2'b00;
  localparam logic [1:0] PCS_TGT = 2'b01;
  localparam logic [1:0] PCS_JMP = 2'b10;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       ir_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       iord;
    logic       reg_wr;
    logic       reg_dst;
    logic       mem_to_reg;
    logic [1:0] alu_op;
    logic       src_a;
    logic [2:0] src_b;
    logic [1:0] pc_src;
  } ctrl_t;
endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  input  logic [OP_W-1:0]    opcode,
  output logic [STATE_W-1:0] next,
  output logic               back_to_fetch
);
  // Opcode dispatch out of the decode state.
  function automatic logic [STATE_W-1:0] decode_target(input logic [OP_W-1:0] op);
    case (op)
      OP_RR:        return S_REXE;
      OP_JMP:       return S_JMP;
      OP_BEQ:       return S_BRDONE;
      OP_ORI:       return S_ORIEXE;
      OP_LD, OP_ST: return S_ADDR;
      default:      return S_FETCH;
    endcase
  endfunction

  // Split of the memory path after address calculation.
  function automatic logic [STATE_W-1:0] addr_target(input logic [OP_W-1:0] op);
    return (op == OP_ST) ? S_STMEM : S_LDMEM;
  endfunction

  always_comb begin
    case (state)
      S_FETCH:  next = S_DECODE;
      S_DECODE: next = decode_target(opcode);
      S_ADDR:   next = addr_target(opcode);
      S_LDMEM:  next = S_LDWB;
      S_REXE:   next = S_RFIN;
      S_ORIEXE: next = S_ORIFIN;
      default:  next = S_FETCH;
    endcase
  end

  assign back_to_fetch = (next == S_FETCH);
endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  output ctrl_t              ctrl
);
  always_comb begin
    ctrl = '0;
    case (state)
      S_FETCH: begin
        ctrl.pc_wr = 1'b1; ctrl.ir_wr = 1'b1; ctrl.mem_rd = 1'b1;
        ctrl.alu_op = ALU_ADD; ctrl.src_b = SB_FOUR; ctrl.pc_src = PCS_ALU;
      end
      S_DECODE: begin
        ctrl.alu_op = ALU_ADD; ctrl.src_b = SB_SHL2;
      end
      S_ADDR: begin
        ctrl.src_a = 1'b1; ctrl.src_b = SB_SEXT;
      end
      S_LDMEM: begin
        ctrl.mem_rd = 1'b1; ctrl.iord = 1'b1;
        ctrl.src_a = 1'b1; ctrl.src_b = SB_SEXT;
      end
      S_LDWB: begin
        ctrl.reg_wr = 1'b1; ctrl.mem_to_reg = 1'b1;
        ctrl.src_a = 1'b1; ctrl.src_b = SB_SEXT;
      end
      S_STMEM: begin
        ctrl.mem_wr = 1'b1; ctrl.iord = 1'b1;
        ctrl.src_a = 1'b1; ctrl.src_b = SB_SEXT;
      end
      S_REXE: begin
        ctrl.reg_dst = 1'b1; ctrl.alu_op = ALU_FN;
        ctrl.src_a = 1'b1; ctrl.src_b = SB_RT;
      end
      S_RFIN: begin
        ctrl.reg_wr = 1'b1; ctrl.reg_dst = 1'b1; ctrl.alu_op = ALU_FN;
        ctrl.src_a = 1'b1; ctrl.src_b = SB_RT;
      end
      S_BRDONE: begin
        ctrl.pc_wr_cond = 1'b1; ctrl.alu_op = ALU_SUB;
        ctrl.src_a = 1'b1; ctrl.pc_src = PCS_TGT;
      end
      S_JMP: begin
        ctrl.pc_wr = 1'b1; ctrl.pc_src = PCS_JMP;
      end
      S_ORIEXE: begin
        ctrl.alu_op = ALU_OR; ctrl.src_a = 1'b1; ctrl.src_b = SB_ZEXT;
      end
      S_ORIFIN: begin
        ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_OR;
        ctrl.src_a = 1'b1; ctrl.src_b = SB_ZEXT;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic [3:0] state_o,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       ir_wr,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       iord,
  output logic       reg_wr,
  output logic       reg_dst,
  output logic       mem_to_reg,
  output logic [1:0] alu_op,
  output logic       alu_src_a,
  output logic [2:0] alu_src_b,
  output logic [1:0] pc_src
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic               back_to_fetch;
  ctrl_t              ctrl;

  mcc_state_reg #(.W(STATE_W)) u_sreg (
    .clk(clk), .rst(rst), .d(state_d), .q(state_q)
  );

  mcc_next_state u_ns (
    .state(state_q), .opcode(opcode), .next(state_d), .back_to_fetch(back_to_fetch)
  );

  mcc_ctrl_decode u_dec (
    .state(state_q), .ctrl(ctrl)
  );

  assign state_o    = state_q;
  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign ir_wr      = ctrl.ir_wr;
  assign mem_rd     = ctrl.mem_rd;
  assign mem_wr     = ctrl.mem_wr;
  assign iord       = ctrl.iord;
  assign reg_wr     = ctrl.reg_wr;
  assign reg_dst    = ctrl.reg_dst;
  assign mem_to_reg = ctrl.mem_to_reg;
  assign alu_op     = ctrl.alu_op;
  assign alu_src_a  = ctrl.src_a;
  assign alu_src_b  = ctrl.src_b;
  assign pc_src     = ctrl.pc_src;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic [3:0] state,
  input logic       back_to_fetch,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       reg_wr,
  input logic       mem_wr,
  input logic [1:0] alu_op
);
  logic op_known;
  assign op_known = (opcode == 6'b000000) || (opcode == 6'b000010) ||
                    (opcode == 6'b000100) || (opcode == 6'b001011) ||
                    (opcode == 6'b100011) || (opcode == 6'b101011);

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    state == 4'd0 |=> state == 4'd1);

  assert_state_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    state < 4'd12);

  assert_dispatch_rr_R3: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 && opcode == 6'b000000) |=> state == 4'd6);

  assert_dispatch_jmp_R3: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 && opcode == 6'b000010) |=> state == 4'd9);

  assert_store_split_R4: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd2 && opcode == 6'b101011) |=> state == 4'd5);

  assert_chain_R4: assert property (@(posedge clk) disable iff (rst)
    state == 4'd10 |=> state == 4'd11);

  assert_return_R5: assert property (@(posedge clk) disable iff (rst)
    (state inside {4'd4, 4'd5, 4'd7, 4'd8, 4'd9, 4'd11}) |=> state == 4'd0);

  assert_fetch_flag_R5: assert property (@(posedge clk) disable iff (rst)
    back_to_fetch |=> state == 4'd0);

  assert_bad_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 && !op_known) |=> (state == 4'd0));

  assert_cond_uses_sub_R10: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> alu_op == 2'b01);

  assert_pc_write_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_wr, pc_wr_cond}));

  assert_regwr_states_R11: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> (state inside {4'd4, 4'd7, 4'd11}));

  assert_memwr_store_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> state == 4'd5);
endmodule

bind mc_ctrl_fsm mcc_checker u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .state(state_q),
  .back_to_fetch(back_to_fetch), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .reg_wr(reg_wr), .mem_wr(mem_wr), .alu_op(alu_op)
);

// File: tb/sim_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic [3:0] state_o;
  logic pc_wr, pc_wr_cond, ir_wr, mem_rd, mem_wr, iord, reg_wr, reg_dst, mem_to_reg;
  logic [1:0] alu_op, pc_src;
  logic       alu_src_a;
  logic [2:0] alu_src_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mc_ctrl_fsm u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .iord(iord), .reg_wr(reg_wr), .reg_dst(reg_dst),
    .mem_to_reg(mem_to_reg), .alu_op(alu_op), .alu_src_a(alu_src_a),
    .alu_src_b(alu_src_b), .pc_src(pc_src)
  );

  // Vector: opcode, then the visited states from decode onward, one nibble each,
  // ending at the first 0 after the leading 1.
  localparam logic [29:0] VEC [8] = '{
    {6'b000000, 24'h167000},  // register-register
    {6'b000010, 24'h190000},  // jump
    {6'b000100, 24'h180000},  // branch-if-equal
    {6'b001011, 24'h1AB000},  // or-immediate
    {6'b100011, 24'h123400},  // load
    {6'b101011, 24'h125000},  // store
    {6'b111111, 24'h100000},  // unknown
    {6'b000001, 24'h100000}   // unknown, next to a legal code
  };

  // Control word:
  // {pc_wr, pc_wr_cond, ir_wr, mem_rd, mem_wr, iord, reg_wr, reg_dst, mem_to_reg,
  //  alu_op[1:0], src_a, src_b[2:0], pc_src[1:0]}
  function automatic logic [16:0] want(input logic [3:0] s);
    logic [8:0] en;
    logic [1:0] op;
    logic       a;
    logic [2:0] b;
    logic [1:0] ps;
    en = '0; op = 2'b00; a = 1'b0; b = 3'b000; ps = 2'b00;
    case (s)
      4'd0:  begin en = 9'b101100000; b = 3'b001; end
      4'd1:  b = 3'b011;
      4'd2:  begin a = 1; b = 3'b010; end
      4'd3:  begin en = 9'b000101000; a = 1; b = 3'b010; end
      4'd4:  begin en = 9'b000000101; a = 1; b = 3'b010; end
      4'd5:  begin en = 9'b000011000; a = 1; b = 3'b010; end
      4'd6:  begin en = 9'b000000010; op = 2'b10; a = 1; end
      4'd7:  begin en = 9'b000000110; op = 2'b10; a = 1; end
      4'd8:  begin en = 9'b010000000; op = 2'b01; a = 1; ps = 2'b01; end
      4'd9:  begin en = 9'b100000000; ps = 2'b10; end
      4'd10: begin op = 2'b11; a = 1; b = 3'b100; end
      4'd11: begin en = 9'b000000100; op = 2'b11; a = 1; b = 3'b100; end
      default: ;
    endcase
    return {en, op, a, b, ps};
  endfunction

  function automatic logic [16:0] seen();
    return {pc_wr, pc_wr_cond, ir_wr, mem_rd, mem_wr, iord, reg_wr, reg_dst,
            mem_to_reg, alu_op, alu_src_a, alu_src_b, pc_src};
  endfunction

  task automatic check_at(input logic [3:0] s, input string req);
    checks++;
    if (state_o !== s) begin
      fails++;
      $display("FAIL %s state: actual %0d expected %0d", req, state_o, s);
    end
    checks++;
    if (seen() !== want(s)) begin
      fails++;
      $display("FAIL %s controls in state %0d: actual %b expected %b", req, s, seen(), want(s));
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] path;
    logic [3:0]  nib;
    rst = 1'b1;
    tick(); tick();
    check_at(4'd0, "R1 reset R7");
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R8 R9 R10 R11
    for (int v = 0; v < 8; v++) begin
      opcode = VEC[v][29:24];
      path   = VEC[v][23:0];
      check_at(4'd0, "R2 fetch R7");
      for (int k = 0; k < 6; k++) begin
        nib = path[23 - 4*k -: 4];
        tick();
        check_at(nib, (v >= 6) ? "R6 unknown opcode" : "R3 R4 R5 path");
        if (nib == 4'd0 && k > 0) break;
      end
    end

    // R12: opcode changes outside states 1 and 2 are ignored.
    opcode = 6'b000100;
    tick(); check_at(4'd1, "R12 fetch ignores opcode");
    opcode = 6'b100011;
    tick(); check_at(4'd2, "R3 load dispatch");
    tick(); check_at(4'd3, "R4 load split");
    opcode = 6'b101011;
    tick(); check_at(4'd4, "R12 state 3 ignores opcode");
    opcode = 6'b000000;
    tick(); check_at(4'd0, "R12 state 4 ignores opcode R5");

    // R4: a non-store opcode in state 2 goes down the load path.
    opcode = 6'b101011;
    tick(); check_at(4'd1, "R2");
    tick(); check_at(4'd2, "R3 store dispatch");
    opcode = 6'b000100;
    tick(); check_at(4'd3, "R4 non-store in state 2");
    tick(); check_at(4'd4, "R4");
    tick(); check_at(4'd0, "R5");

    // R1: reset in mid path.
    opcode = 6'b001011;
    tick(); check_at(4'd1, "R2");
    tick(); check_at(4'd10, "R3 ori dispatch");
    rst = 1'b1;
    tick(); check_at(4'd0, "R1 mid-path reset");
    tick(); check_at(4'd0, "R1 reset held");
    rst = 1'b0;
    tick(); check_at(4'd1, "R1 release R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule